// File: doc/BRIEF.md
# DMA Channel Event Admission Gate

This block decides which DMA channel is handed next to the transfer-request queue. Each of 64 channels can be triggered in three ways: a software trigger, an external event line, or a chain trigger from a finished transfer. Any trigger marks the channel as pending. Every clock, a fixed-priority picker takes the lowest-numbered channel that is pending and not already in the queue. It places that channel in a one-entry output slot that drives the queue through a valid/ready handshake.

When a channel is admitted, its "in queue" flag is set. The flag keeps the channel out of the picker until it is cleared. Hardware clears it when the queued transfer is consumed, and software clears it by writing ones into a clear word. A trigger that arrives while the flag is set is kept pending and is serviced once the flag drops. Software sees the 64 flags as two 32-bit read-only words.

Top module: `dma_admit_gate`

## Requirements
- R1: After reset, both flag words read 0 and `q_valid_o` is low.
- R2: A software trigger, an external event and a chain trigger on the same channel set one shared pending bit. Any number of them, in one cycle or in several before admission, leads to exactly one admission.
- R3: At most one channel is admitted per clock. It is the lowest-numbered channel that is pending and has its flag at 0. Admission happens only when the output slot is empty or `q_ready_i` is high in that cycle.
- R4: A channel's pending bit is registered at the edge after its trigger, and it is admitted at the following edge. At that admission edge, `q_valid_o` goes high, `q_ch_o` carries the channel number, and the channel's flag bit goes to 1. A flag bit never rises in any other way.
- R5: A channel whose flag is 1 is never admitted again. A trigger that arrives meanwhile stays pending, and the channel is admitted once the flag is cleared.
- R6: `hw_done_vld_i` with channel number `hw_done_ch_i` clears that channel's flag at the next edge.
- R7: A software clear write sets `sw_clr_lo_we_i` or `sw_clr_hi_we_i`. Each 1 in `sw_clr_data_i` clears one flag, and each 0 leaves its flag unchanged. Bit k of the low word maps to channel k and bit k of the high word maps to channel 32+k. The flag words map the same way: `flag_lo_o` holds channels 0–31 and `flag_hi_o` holds channels 32–63.
- R8: A hardware clear and a software clear of the same bit in one cycle clear it. A clear of a channel in the same cycle as its admission leaves the flag at 1.
- R9: While `q_valid_o` is high and `q_ready_i` is low, `q_valid_o` and `q_ch_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| man_trig_i | input | 64 | Software trigger, one bit per channel |
| ext_evt_i | input | 64 | External event lines, one bit per channel |
| chain_trig_i | input | 64 | Chain triggers, one bit per channel |
| hw_done_vld_i | input | 1 | A queued transfer was consumed |
| hw_done_ch_i | input | 6 | Channel of the consumed transfer |
| sw_clr_lo_we_i | input | 1 | Software clear write to channels 0–31 |
| sw_clr_hi_we_i | input | 1 | Software clear write to channels 32–63 |
| sw_clr_data_i | input | 32 | Write-one-to-clear data |
| q_valid_o | output | 1 | Output slot holds an admitted channel |
| q_ch_o | output | 6 | Admitted channel number |
| q_ready_i | input | 1 | Queue takes the slot this cycle |
| flag_lo_o | output | 32 | In-queue flags, channels 0–31 |
| flag_hi_o | output | 32 | In-queue flags, channels 32–63 |

## Verification
The assertions assume that `q_ready_i` is a plain level the queue may drive at any time. They also assume that `hw_done_ch_i` always names a channel in range, which the 6-bit width ensures for 64 channels. They make no assumption about which channels are cleared or when. The stimulus keeps within this: `q_ready_i` is random, hardware clears name random channels, and clears may land on flags that are already 0 or on channels being admitted in the same cycle. No input is held back to suit the design.

// File: rtl/dma_admit_pkg.sv
package dma_admit_pkg;
    localparam int DEF_WORD_W = 32;
    localparam int NUM_WORDS  = 2;
endpackage

// File: rtl/dma_admit_trig.sv
module dma_admit_trig #(
    parameter int NUM_CH = 64
) (
    input  logic [NUM_CH-1:0] man_i,
    input  logic [NUM_CH-1:0] ext_i,
    input  logic [NUM_CH-1:0] chain_i,
    input  logic [NUM_CH-1:0] pend_q_i,
    input  logic [NUM_CH-1:0] take_i,
    output logic [NUM_CH-1:0] pend_d_o
);
    // Sources merge into one bit per channel; a fresh trigger in the
    // admission cycle survives so it is not lost.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            pend_d_o[c] = (pend_q_i[c] & ~take_i[c]) | man_i[c] | ext_i[c] | chain_i[c];
        end
    end
endmodule

// File: rtl/dma_admit_pick.sv
module dma_admit_pick #(
    parameter int NUM_CH = 64,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [NUM_CH-1:0] onehot_o
);
    // Isolate lowest set bit, then encode it.
    always_comb begin
        onehot_o = req_i & (~req_i + NUM_CH'(1));
        found_o  = |req_i;
        idx_o    = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (onehot_o[c]) idx_o = IDX_W'(c);
        end
    end
endmodule

// File: rtl/dma_admit_clr.sv
module dma_admit_clr #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 2,
    parameter int NUM_CH    = WORD_W * NUM_WORDS,
    parameter int IDX_W     = $clog2(NUM_CH)
) (
    input  logic                 hw_vld_i,
    input  logic [IDX_W-1:0]     hw_ch_i,
    input  logic [NUM_WORDS-1:0] sw_we_i,
    input  logic [WORD_W-1:0]    sw_data_i,
    output logic [NUM_CH-1:0]    clr_o
);
    logic [NUM_CH-1:0] sw_mask;
    logic [NUM_CH-1:0] hw_mask;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_comb begin
            sw_mask[w*WORD_W +: WORD_W] = sw_we_i[w] ? sw_data_i : '0;
        end
    end

    always_comb begin
        hw_mask = hw_vld_i ? (NUM_CH'(1) << hw_ch_i) : '0;
        clr_o   = hw_mask | sw_mask;
    end
endmodule

// File: rtl/dma_admit_gate.sv
module dma_admit_gate #(
    parameter int WORD_W = dma_admit_pkg::DEF_WORD_W,
    localparam int NUM_CH = WORD_W * dma_admit_pkg::NUM_WORDS,
    localparam int IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] man_trig_i,
    input  logic [NUM_CH-1:0] ext_evt_i,
    input  logic [NUM_CH-1:0] chain_trig_i,
    input  logic              hw_done_vld_i,
    input  logic [IDX_W-1:0]  hw_done_ch_i,
    input  logic              sw_clr_lo_we_i,
    input  logic              sw_clr_hi_we_i,
    input  logic [WORD_W-1:0] sw_clr_data_i,
    output logic              q_valid_o,
    output logic [IDX_W-1:0]  q_ch_o,
    input  logic              q_ready_i,
    output logic [WORD_W-1:0] flag_lo_o,
    output logic [WORD_W-1:0] flag_hi_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic [NUM_CH-1:0] flag;
        logic              vld;
        logic [IDX_W-1:0]  ch;
    } gate_state_t;

    gate_state_t s_q, s_d;

    logic [NUM_CH-1:0] req;
    logic              found;
    logic [IDX_W-1:0]  pick_idx;
    logic [NUM_CH-1:0] pick_oh;
    logic              take;
    logic [NUM_CH-1:0] take_mask;
    logic [NUM_CH-1:0] pend_nxt;
    logic [NUM_CH-1:0] clr_mask;

    assign req = s_q.pend & ~s_q.flag;

    dma_admit_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .req_i    (req),
        .found_o  (found),
        .idx_o    (pick_idx),
        .onehot_o (pick_oh)
    );

    assign take      = found & (~s_q.vld | q_ready_i);
    assign take_mask = take ? pick_oh : '0;

    dma_admit_trig #(.NUM_CH(NUM_CH)) u_trig (
        .man_i    (man_trig_i),
        .ext_i    (ext_evt_i),
        .chain_i  (chain_trig_i),
        .pend_q_i (s_q.pend),
        .take_i   (take_mask),
        .pend_d_o (pend_nxt)
    );

    dma_admit_clr #(
        .WORD_W(WORD_W), .NUM_WORDS(dma_admit_pkg::NUM_WORDS),
        .NUM_CH(NUM_CH), .IDX_W(IDX_W)
    ) u_clr (
        .hw_vld_i  (hw_done_vld_i),
        .hw_ch_i   (hw_done_ch_i),
        .sw_we_i   ({sw_clr_hi_we_i, sw_clr_lo_we_i}),
        .sw_data_i (sw_clr_data_i),
        .clr_o     (clr_mask)
    );

    always_comb begin
        s_d      = s_q;
        s_d.pend = pend_nxt;
        // Admission is applied after the clear, so it wins on a tie.
        s_d.flag = (s_q.flag & ~clr_mask) | take_mask;
        if (take) begin
            s_d.vld = 1'b1;
            s_d.ch  = pick_idx;
        end else if (s_q.vld && q_ready_i) begin
            s_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_valid_o = s_q.vld;
    assign q_ch_o    = s_q.ch;
    assign flag_lo_o = s_q.flag[WORD_W-1:0];
    assign flag_hi_o = s_q.flag[NUM_CH-1:WORD_W];
endmodule

// File: rtl/dma_admit_gate_chk.sv
module dma_admit_gate_chk #(
    parameter int WORD_W = 32,
    parameter int NUM_CH = 64,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_done_vld_i,
    input logic [IDX_W-1:0]  hw_done_ch_i,
    input logic              q_valid_o,
    input logic [IDX_W-1:0]  q_ch_o,
    input logic              q_ready_i,
    input logic [WORD_W-1:0] flag_lo_o,
    input logic [WORD_W-1:0] flag_hi_o
);
    logic [NUM_CH-1:0] flag_all;
    logic [NUM_CH-1:0] prev_flags;
    logic [NUM_CH-1:0] risen;
    logic              prev_vld;
    logic              prev_rdy;
    logic              prev_hw;
    logic [IDX_W-1:0]  prev_hw_ch;
    logic              load;

    assign flag_all = {flag_hi_o, flag_lo_o};
    assign risen    = flag_all & ~prev_flags;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_flags <= '0;
            prev_vld   <= 1'b0;
            prev_rdy   <= 1'b0;
            prev_hw    <= 1'b0;
            prev_hw_ch <= '0;
        end else begin
            prev_flags <= flag_all;
            prev_vld   <= q_valid_o;
            prev_rdy   <= q_ready_i;
            prev_hw    <= hw_done_vld_i;
            prev_hw_ch <= hw_done_ch_i;
        end
    end

    // A new entry entered the output slot at the last edge.
    assign load = q_valid_o && (!prev_vld || prev_rdy);

    // R1: reset clears the slot
    a_r1_reset_slot: assert property (@(posedge clk)
        !rst_n |=> !q_valid_o);

    // R9: slot holds while stalled
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid_o && !q_ready_i) |=> (q_valid_o && $stable(q_ch_o)));

    // R4: loaded channel carries its flag
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> flag_all[q_ch_o]);

    // R4: a flag rises only for the channel just loaded
    a_r4_rise_only_load: assert property (@(posedge clk) disable iff (!rst_n)
        (risen != '0) |-> (load && risen == (NUM_CH'(1) << q_ch_o)));

    // R5: a flagged channel is never loaded again
    a_r5_no_readmit: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !prev_flags[q_ch_o]);

    // R6: hardware clear takes effect unless the channel was admitted
    a_r6_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        prev_hw |-> (!flag_all[prev_hw_ch] || (load && q_ch_o == prev_hw_ch)));
endmodule

bind dma_admit_gate dma_admit_gate_chk #(
    .WORD_W(WORD_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_done_vld_i (hw_done_vld_i),
    .hw_done_ch_i  (hw_done_ch_i),
    .q_valid_o     (q_valid_o),
    .q_ch_o        (q_ch_o),
    .q_ready_i     (q_ready_i),
    .flag_lo_o     (flag_lo_o),
    .flag_hi_o     (flag_hi_o)
);

// File: tb/dma_admit_gate_bench.sv
module dma_admit_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] man = '0, ext = '0, chn = '0;
    logic        hw_vld = 1'b0;
    logic [5:0]  hw_ch = '0;
    logic        lo_we = 1'b0, hi_we = 1'b0;
    logic [31:0] clr_data = '0;
    logic        q_valid;
    logic [5:0]  q_ch;
    logic        q_ready = 1'b0;
    logic [31:0] flag_lo, flag_hi;

    int vectors = 0;
    int errs = 0;

    // reference state
    bit m_pend[N];
    bit m_flag[N];
    bit m_vld;
    int m_ch;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_admit_gate u_dma_admit_gate (
        .clk(clk), .rst_n(rst_n),
        .man_trig_i(man), .ext_evt_i(ext), .chain_trig_i(chn),
        .hw_done_vld_i(hw_vld), .hw_done_ch_i(hw_ch),
        .sw_clr_lo_we_i(lo_we), .sw_clr_hi_we_i(hi_we), .sw_clr_data_i(clr_data),
        .q_valid_o(q_valid), .q_ch_o(q_ch), .q_ready_i(q_ready),
        .flag_lo_o(flag_lo), .flag_hi_o(flag_hi)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flags();
        logic [63:0] v;
        for (int i = 0; i < N; i++) v[i] = m_flag[i];
        return v;
    endfunction

    task automatic model_step();
        int win;
        bit take;
        bit clr[N];
        if (!rst_n) begin
            foreach (m_pend[i]) begin m_pend[i] = 0; m_flag[i] = 0; end
            m_vld = 0; m_ch = 0;
            return;
        end
        win = -1;
        for (int i = N - 1; i >= 0; i--) if (m_pend[i] && !m_flag[i]) win = i;
        take = (win >= 0) && (!m_vld || q_ready);
        for (int i = 0; i < N; i++) begin
            clr[i] = (hw_vld && hw_ch == i)
                  || (lo_we && i < 32 && clr_data[i % 32])
                  || (hi_we && i >= 32 && clr_data[i % 32]);
        end
        for (int i = 0; i < N; i++) begin
            bit t;
            t = take && (i == win);
            if (clr[i]) m_flag[i] = 0;
            if (t) m_flag[i] = 1;
            if (t) m_pend[i] = 0;
            if (man[i] || ext[i] || chn[i]) m_pend[i] = 1;
        end
        if (take) begin m_vld = 1; m_ch = win; end
        else if (m_vld && q_ready) m_vld = 0;
    endtask

    // one clock: model follows the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R3 valid", {63'd0, q_valid}, {63'd0, m_vld});
        if (m_vld) chk("R3 channel", {58'd0, q_ch}, 64'(m_ch));
        chk("R4 flags", {flag_hi, flag_lo}, model_flags());
    endtask

    task automatic idle_in();
        man = '0; ext = '0; chn = '0;
        hw_vld = 0; lo_we = 0; hi_we = 0; clr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R1 flags after reset", {flag_hi, flag_lo}, 64'd0);
        chk("R1 valid after reset", {63'd0, q_valid}, 64'd0);

        // R2: three sources on ch5 together, plus ch40; slot stalled
        q_ready = 0;
        man[5] = 1; ext[5] = 1; chn[5] = 1; man[40] = 1;
        tick();
        idle_in();
        tick();
        chk("R4 admit ch5 valid", {63'd0, q_valid}, 64'd1);
        chk("R4 admit ch5 number", {58'd0, q_ch}, 64'd5);
        chk("R4 ch5 flag", {32'd0, flag_lo}, 64'h20);
        tick();
        chk("R9 hold ch", {58'd0, q_ch}, 64'd5);
        chk("R3 no admit while full", {32'd0, flag_hi}, 64'd0);
        q_ready = 1;
        tick();
        chk("R3 ch40 next", {58'd0, q_ch}, 64'd40);
        chk("R7 ch40 in high word", {32'd0, flag_hi}, 64'h100);
        tick();
        chk("R2 no stacked admission", {63'd0, q_valid}, 64'd0);

        // R5: retrigger flagged ch5
        ext[5] = 1;
        tick();
        idle_in();
        tick();
        chk("R5 flagged not admitted", {63'd0, q_valid}, 64'd0);
        lo_we = 1; clr_data = 32'd0;
        tick();
        idle_in();
        chk("R7 write zero no effect", {32'd0, flag_lo}, 64'h20);
        hi_we = 1; clr_data = 32'h100;
        tick();
        idle_in();
        chk("R7 high clear", {32'd0, flag_hi}, 64'd0);
        hw_vld = 1; hw_ch = 6'd5;
        tick();
        idle_in();
        chk("R6 hw clear", {32'd0, flag_lo}, 64'd0);
        tick();
        chk("R5 pending kept, admitted", {58'd0, q_ch}, 64'd5);
        chk("R5 readmit valid", {63'd0, q_valid}, 64'd1);

        // R8: clear coinciding with admission of ch7
        man[7] = 1;
        tick();
        idle_in();
        lo_we = 1; clr_data = 32'h80; hw_vld = 1; hw_ch = 6'd7;
        tick();
        idle_in();
        chk("R8 admit beats clear", {32'd0, flag_lo}, 64'hA0);
        lo_we = 1; clr_data = 32'h20; hw_vld = 1; hw_ch = 6'd5;
        tick();
        idle_in();
        chk("R8 hw+sw clear", {32'd0, flag_lo}, 64'h80);

        // R3: lowest number first
        man[63] = 1; ext[3] = 1; chn[2] = 1;
        tick();
        idle_in();
        tick();
        chk("R3 order first", {58'd0, q_ch}, 64'd2);
        tick();
        chk("R3 order second", {58'd0, q_ch}, 64'd3);
        tick();
        chk("R3 order third", {58'd0, q_ch}, 64'd63);

        // random traffic checked against the model every cycle
        for (int cyc = 0; cyc < 4000; cyc++) begin
            idle_in();
            if ($urandom_range(3) == 0) man[$urandom_range(63)] = 1;
            if ($urandom_range(3) == 0) ext[$urandom_range(63)] = 1;
            if ($urandom_range(5) == 0) chn[$urandom_range(63)] = 1;
            if ($urandom_range(2) == 0) begin hw_vld = 1; hw_ch = 6'($urandom_range(63)); end
            if ($urandom_range(9) == 0) begin
                lo_we = ($urandom_range(1) == 0);
                hi_we = ($urandom_range(1) == 0);
                clr_data = $urandom();
            end
            q_ready = ($urandom_range(2) != 0);
            tick();
        end
        idle_in();
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule